// File: doc/BRIEF.md
# Early Receive Event Tracker

This block follows one received frame at a time as the MAC delivers it: a frame-start pulse, a strobe per received byte, a pulse when the destination address has passed the address filter, and an end pulse that carries the CRC verdict. From these it keeps a small event register that lets the host start work on a frame before the frame has finished. Two early-progress bits hand off to each other as the frame grows. Three completion bits record how the frame ended and stay set until the host reads them.

The host reads the event register through a single read strobe. The read returns the current bits and clears the completion bits. The early bits are owned by the frame state machine and are never cleared by a read. Each event can raise the interrupt line if its own enable bit is set. A global enable gates the line, and the line drops at the next host read.

The controller has four states. `ST_IDLE` waits for a frame. `ST_HDR` counts header bytes until the filter passes. `ST_ADDR` means the destination is accepted and fewer than the early threshold of bytes have arrived. `ST_BULK` means the threshold has been passed. The transitions are:
- start: any state to `ST_HDR`.
- filter pass: `ST_HDR` to `ST_ADDR`.
- threshold reached: `ST_ADDR` to `ST_BULK`.
- frame end: `ST_HDR`, `ST_ADDR` or `ST_BULK` to `ST_IDLE`.

Top module: `erx_event_tracker`

## Requirements
- R1: After reset the event register reads 0 and the interrupt line is low. Event bit positions are bit 0 destination accepted, bit 1 early threshold reached, bit 2 good frame, bit 3 CRC error, bit 4 runt. The enable vector uses the same positions.
- R2: One cycle after a filter-pass pulse in a frame that has started and not yet passed, bit 0 is set.
- R3: In the cycle after the byte that brings an accepted frame to EARLY_BYTES (default 128) bytes, bit 1 is set and bit 0 is cleared at the same moment. The two early bits are never set together.
- R4: A host read does not clear bit 0 or bit 1. A new start pulse clears both of them.
- R5: An end pulse on an accepted frame of at least MIN_BYTES (default 64) bytes clears both early bits. It sets bit 2 if the CRC flag is high, otherwise bit 3.
- R6: An end pulse on an accepted frame shorter than MIN_BYTES clears the early bits and sets bit 4. It also sets bit 3 if the CRC flag is low, and then both stay visible until read.
- R7: A frame whose destination never passed the filter sets no event bit and raises no interrupt.
- R8: Bits 2 to 4 stay set until a host read. The read returns their value and clears them, except for a bit that is set again in the same cycle as the read.
- R9: An event raises the interrupt only if its enable bit is set, and the line is low whenever the global enable is low.
- R10: The interrupt line is low after a host read unless a new enabled event is set in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_start | input | 1 | Pulse: a new frame begins |
| rx_byte_vld | input | 1 | One received byte in this cycle |
| rx_da_pass | input | 1 | Pulse: destination address passed the filter |
| rx_end | input | 1 | Pulse: frame ended |
| rx_crc_ok | input | 1 | CRC good, sampled with rx_end |
| ev_ie | input | 5 | Per-event interrupt enables |
| irq_gie | input | 1 | Global interrupt enable |
| rd_strobe | input | 1 | Host read of the event register |
| rd_data | output | 5 | Current event register value |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a frame end that lands in the same cycle as a host read. That read must return the old completion bits, and the new completion bit must survive the clear. The bench drives this cycle directly, with the end pulse and the read strobe raised together. It also drives a read taken between the filter pass and the early threshold, which checks that the early bit outlives the read. Short frames with bad CRC are forced so that the runt and CRC-error bits latch together. Random frames with random lengths, filter results and enables cover the rest.

// File: rtl/erx_pkg.sv
package erx_pkg;

    localparam int EV_W     = 5;
    localparam int EV_DEST  = 0;
    localparam int EV_BLK   = 1;
    localparam int EV_OK    = 2;
    localparam int EV_CRC   = 3;
    localparam int EV_RUNT  = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_ADDR = 2'd2,
        ST_BULK = 2'd3
    } erx_state_t;

    typedef struct packed {
        logic cnt_clr;
        logic cnt_inc;
        logic dest_set;
        logic dest_clr;
        logic blk_set;
        logic blk_clr;
        logic ok_set;
        logic crc_set;
        logic runt_set;
    } erx_act_t;

endpackage

// File: rtl/erx_byte_counter.sv
module erx_byte_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/erx_frame_fsm.sv
module erx_frame_fsm
    import erx_pkg::*;
#(
    parameter int CNT_W       = 11,
    parameter int EARLY_BYTES = 128,
    parameter int MIN_BYTES   = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_start,
    input  logic             rx_byte_vld,
    input  logic             rx_da_pass,
    input  logic             rx_end,
    input  logic             rx_crc_ok,
    input  logic [CNT_W-1:0] cnt,
    output erx_act_t         act,
    output erx_state_t       state
);

    localparam logic [CNT_W:0] EARLY_C = (CNT_W+1)'(EARLY_BYTES);
    localparam logic [CNT_W:0] MIN_C   = (CNT_W+1)'(MIN_BYTES);

    erx_state_t     nxt;
    logic [CNT_W:0] eff;

    assign eff = {1'b0, cnt} + {{CNT_W{1'b0}}, rx_byte_vld};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        act = '0;
        nxt = state;
        if (rx_start) begin
            act.cnt_clr  = 1'b1;
            act.dest_clr = 1'b1;
            act.blk_clr  = 1'b1;
            nxt          = ST_HDR;
        end else begin
            act.cnt_inc = rx_byte_vld && (state != ST_IDLE);
            unique case (state)
                ST_IDLE: begin
                    nxt = ST_IDLE;
                end
                ST_HDR: begin
                    if (rx_end) begin
                        act.cnt_clr = 1'b1;
                        nxt         = ST_IDLE;
                    end else if (rx_da_pass) begin
                        act.dest_set = 1'b1;
                        nxt          = ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (rx_end) begin
                        act.dest_clr = 1'b1;
                        act.blk_clr  = 1'b1;
                        act.cnt_clr  = 1'b1;
                        if (eff < MIN_C) begin
                            act.runt_set = 1'b1;
                            act.crc_set  = !rx_crc_ok;
                        end else begin
                            act.ok_set  = rx_crc_ok;
                            act.crc_set = !rx_crc_ok;
                        end
                        nxt = ST_IDLE;
                    end else if (eff >= EARLY_C) begin
                        act.blk_set  = 1'b1;
                        act.dest_clr = 1'b1;
                        nxt          = ST_BULK;
                    end
                end
                ST_BULK: begin
                    if (rx_end) begin
                        act.dest_clr = 1'b1;
                        act.blk_clr  = 1'b1;
                        act.cnt_clr  = 1'b1;
                        act.ok_set   = rx_crc_ok;
                        act.crc_set  = !rx_crc_ok;
                        nxt          = ST_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/erx_event_regs.sv
module erx_event_regs
    import erx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  erx_act_t        act,
    input  logic            rd_strobe,
    output logic [EV_W-1:0] ev,
    output logic [EV_W-1:0] set_vec
);

    always_comb begin
        set_vec          = '0;
        set_vec[EV_DEST] = act.dest_set;
        set_vec[EV_BLK]  = act.blk_set;
        set_vec[EV_OK]   = act.ok_set;
        set_vec[EV_CRC]  = act.crc_set;
        set_vec[EV_RUNT] = act.runt_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev[EV_DEST] <= 1'b0;
            ev[EV_BLK]  <= 1'b0;
        end else begin
            if (act.dest_set) begin
                ev[EV_DEST] <= 1'b1;
            end else if (act.dest_clr) begin
                ev[EV_DEST] <= 1'b0;
            end
            if (act.blk_set) begin
                ev[EV_BLK] <= 1'b1;
            end else if (act.blk_clr) begin
                ev[EV_BLK] <= 1'b0;
            end
        end
    end

    for (genvar g = EV_OK; g < EV_W; g++) begin : g_sticky
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ev[g] <= 1'b0;
            end else if (set_vec[g]) begin
                ev[g] <= 1'b1;
            end else if (rd_strobe) begin
                ev[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/erx_irq_gen.sv
module erx_irq_gen
    import erx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] set_vec,
    input  logic [EV_W-1:0] ie,
    input  logic            gie,
    input  logic            rd_strobe,
    output logic            irq
);

    logic pend;
    logic hit;

    assign hit = |(set_vec & ie);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (hit) begin
            pend <= 1'b1;
        end else if (rd_strobe) begin
            pend <= 1'b0;
        end
    end

    assign irq = pend && gie;

endmodule

// File: rtl/erx_event_tracker.sv
module erx_event_tracker
    import erx_pkg::*;
#(
    parameter int CNT_W       = 11,
    parameter int EARLY_BYTES = 128,
    parameter int MIN_BYTES   = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_start,
    input  logic            rx_byte_vld,
    input  logic            rx_da_pass,
    input  logic            rx_end,
    input  logic            rx_crc_ok,
    input  logic [4:0]      ev_ie,
    input  logic            irq_gie,
    input  logic            rd_strobe,
    output logic [4:0]      rd_data,
    output logic            irq
);

    erx_act_t         act;
    erx_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [EV_W-1:0]  ev;
    logic [EV_W-1:0]  set_vec;

    erx_byte_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (act.cnt_clr),
        .inc   (act.cnt_inc),
        .cnt   (cnt)
    );

    erx_frame_fsm #(
        .CNT_W       (CNT_W),
        .EARLY_BYTES (EARLY_BYTES),
        .MIN_BYTES   (MIN_BYTES)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_start    (rx_start),
        .rx_byte_vld (rx_byte_vld),
        .rx_da_pass  (rx_da_pass),
        .rx_end      (rx_end),
        .rx_crc_ok   (rx_crc_ok),
        .cnt         (cnt),
        .act         (act),
        .state       (state)
    );

    erx_event_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .rd_strobe (rd_strobe),
        .ev        (ev),
        .set_vec   (set_vec)
    );

    erx_irq_gen irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .ie        (ev_ie),
        .gie       (irq_gie),
        .rd_strobe (rd_strobe),
        .irq       (irq)
    );

    assign rd_data = ev;

endmodule

// File: rtl/erx_checker.sv
module erx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_start,
    input logic       rx_byte_vld,
    input logic       rx_da_pass,
    input logic       rx_end,
    input logic       rd_strobe,
    input logic       irq_gie,
    input logic [4:0] rd_data,
    input logic       irq
);

    a_r3_early_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[1] |-> !rd_data[0]);

    a_r3_blk_from_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[1]) |-> $past(rx_byte_vld));

    a_r2_dest_from_pass: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[0]) |-> $past(rx_da_pass));

    a_r4_read_keeps_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && rd_data[0] && !rx_start && !rx_end && !rx_byte_vld) |=> rd_data[0]);

    a_r5_end_clears_early: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_start || rx_end) |=> (!rd_data[0] && !rd_data[1]));

    a_r8_ok_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe && rd_data[2]) |=> rd_data[2]);

    a_r8_crc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe && rd_data[3]) |=> rd_data[3]);

    a_r6_runt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe && rd_data[4]) |=> rd_data[4]);

    a_r9_gie_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_gie |-> !irq);

    a_r10_read_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !rx_end && !rx_byte_vld && !rx_da_pass) |=> !irq);

endmodule

bind erx_event_tracker erx_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_start    (rx_start),
    .rx_byte_vld (rx_byte_vld),
    .rx_da_pass  (rx_da_pass),
    .rx_end      (rx_end),
    .rd_strobe   (rd_strobe),
    .irq_gie     (irq_gie),
    .rd_data     (rd_data),
    .irq         (irq)
);

// File: tb/erx_event_tracker_tb.sv
`timescale 1ns/1ps
module erx_event_tracker_tb_top;

    localparam int EARLY = 128;
    localparam int MINB  = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_start = 1'b0, rx_byte_vld = 1'b0, rx_da_pass = 1'b0;
    logic       rx_end = 1'b0, rx_crc_ok = 1'b0, irq_gie = 1'b1, rd_strobe = 1'b0;
    logic [4:0] ev_ie = 5'h1f;
    logic [4:0] rd_data;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [4:0] exp_ev = '0;
    logic       exp_pend = 1'b0;
    bit         m_active = 1'b0, m_pass = 1'b0;
    int         m_cnt = 0;

    always #2.5 clk = ~clk;

    erx_event_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_byte_vld(rx_byte_vld),
        .rx_da_pass(rx_da_pass), .rx_end(rx_end), .rx_crc_ok(rx_crc_ok),
        .ev_ie(ev_ie), .irq_gie(irq_gie), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .irq(irq)
    );

    function automatic logic exp_irq();
        return exp_pend && irq_gie;
    endfunction

    task automatic chk_ev(string req, logic [4:0] act, logic [4:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s event act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic chk_irq(string req);
        n_tests++;
        if (irq !== exp_irq()) begin
            n_fail++;
            $display("FAIL %s irq act=%b exp=%b", req, irq, exp_irq());
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic t_start();
        rx_start = 1'b1; cyc(); rx_start = 1'b0;
        m_active = 1'b1; m_pass = 1'b0; m_cnt = 0;
        exp_ev[1:0] = 2'b00;
        chk_ev("R4 start clears early", rd_data, exp_ev);
    endtask

    task automatic t_byte();
        rx_byte_vld = 1'b1; cyc(); rx_byte_vld = 1'b0;
        if (m_active) begin
            m_cnt++;
            if (m_pass && m_cnt == EARLY) begin
                exp_ev[1] = 1'b1; exp_ev[0] = 1'b0;
                if (ev_ie[1]) exp_pend = 1'b1;
                chk_ev("R3 threshold handoff", rd_data, exp_ev);
                chk_irq("R9 threshold irq");
            end
        end
    endtask

    task automatic t_da();
        rx_da_pass = 1'b1; cyc(); rx_da_pass = 1'b0;
        if (m_active && !m_pass) begin
            m_pass = 1'b1;
            exp_ev[0] = 1'b1;
            if (ev_ie[0]) exp_pend = 1'b1;
        end
        chk_ev("R2 destination bit", rd_data, exp_ev);
        chk_irq("R9 destination irq");
    endtask

    task automatic t_end(logic crc);
        rx_end = 1'b1; rx_crc_ok = crc; cyc(); rx_end = 1'b0; rx_crc_ok = 1'b0;
        if (m_active && m_pass) begin
            if (m_cnt < MINB) begin
                exp_ev[4] = 1'b1;
                if (ev_ie[4]) exp_pend = 1'b1;
                if (!crc) begin
                    exp_ev[3] = 1'b1;
                    if (ev_ie[3]) exp_pend = 1'b1;
                end
            end else if (crc) begin
                exp_ev[2] = 1'b1;
                if (ev_ie[2]) exp_pend = 1'b1;
            end else begin
                exp_ev[3] = 1'b1;
                if (ev_ie[3]) exp_pend = 1'b1;
            end
        end
        exp_ev[1:0] = 2'b00;
        m_active = 1'b0;
        chk_ev(m_pass ? "R5/R6 end status" : "R7 rejected frame", rd_data, exp_ev);
        chk_irq("R9 end irq");
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        chk_ev("R8 read value", rd_data, exp_ev);
        cyc(); rd_strobe = 1'b0;
        exp_ev[4:2] = 3'b000;
        exp_pend = 1'b0;
        chk_ev("R8 read clears sticky", rd_data, exp_ev);
        chk_irq("R10 read drops irq");
    endtask

    task automatic run_frame(int len, bit pass, logic crc);
        t_start();
        for (int i = 1; i <= len; i++) begin
            t_byte();
            if (pass && i == 6) t_da();
        end
        t_end(crc);
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        chk_ev("R1 reset events", rd_data, 5'b00000);
        n_tests++;
        if (irq !== 1'b0) begin n_fail++; $display("FAIL R1 irq act=%b exp=0", irq); end

        // R4: read between filter pass and threshold keeps bit 0; restart clears it
        ev_ie = 5'h1f; irq_gie = 1'b1;
        t_start();
        for (int i = 0; i < 10; i++) t_byte();
        t_da();
        rd_strobe = 1'b1; cyc(); rd_strobe = 1'b0;
        exp_pend = 1'b0;
        chk_ev("R4 read keeps dest", rd_data, exp_ev);
        chk_irq("R10 mid-frame read");
        t_start();
        t_end(1'b1);

        // full frame crossing the threshold, good CRC
        run_frame(200, 1'b1, 1'b1);
        do_read();
        // runt with bad CRC: both bits latch (R6)
        run_frame(20, 1'b1, 1'b0);
        chk_ev("R6 runt and crc both", rd_data, 5'b11000);
        do_read();
        // exact boundaries
        run_frame(MINB, 1'b1, 1'b1);
        do_read();
        run_frame(MINB - 1, 1'b1, 1'b1);
        do_read();
        run_frame(EARLY - 1, 1'b1, 1'b0);
        do_read();
        // rejected frame (R7)
        exp_pend = 1'b0;
        run_frame(150, 1'b0, 1'b1);
        chk_irq("R7 no irq");
        // enables off (R9)
        ev_ie = 5'h00;
        run_frame(100, 1'b1, 1'b1);
        chk_irq("R9 disabled enables");
        do_read();
        ev_ie = 5'h1f; irq_gie = 1'b0;
        run_frame(100, 1'b1, 1'b0);
        chk_irq("R9 global enable low");
        irq_gie = 1'b1; #1;
        chk_irq("R9 global enable high");
        do_read();

        // R8: end and read in the same cycle
        run_frame(80, 1'b1, 1'b1);
        t_start();
        for (int i = 0; i < 70; i++) t_byte();
        t_da();
        rx_end = 1'b1; rx_crc_ok = 1'b0; rd_strobe = 1'b1;
        chk_ev("R8 same-cycle read old value", rd_data, 5'b00101);
        cyc();
        rx_end = 1'b0; rd_strobe = 1'b0;
        exp_ev = 5'b01000; exp_pend = 1'b1; m_active = 1'b0;
        chk_ev("R8 new bit survives read", rd_data, exp_ev);
        chk_irq("R10 new event keeps irq");
        do_read();

        // random frames
        void'($urandom(32'h5eed_1234));
        for (int f = 0; f < 40; f++) begin
            ev_ie   = 5'($urandom);
            irq_gie = ($urandom % 5) != 0;
            run_frame(8 + int'($urandom % 250), ($urandom % 4) != 0, ($urandom % 3) != 0);
            if ($urandom % 2) do_read();
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule